// File: doc/BRIEF.md
# Closed Caption Line Inserter

This block places two caption bytes per field onto one fixed scan line of that field, as a two-level luma waveform. The host loads a byte pair for a field with a one-cycle load pulse. The pair goes into a pending buffer. At the start of the field's caption line, the pending pair is copied into a working copy. For every pixel of the caption window, the block then drives a luma code together with a valid flag. The video path downstream uses that code in place of its own luma while the flag is high.

The caption window is timed in half-bit cells by a fractional accumulator, so the bit rate is exactly 32 times the line rate for either line length. The window carries the following, in order:

- a run-in of seven clock cycles;
- a three-bit start pattern;
- the first byte, LSB first;
- the second byte, LSB first.

Each field has a pending flag. It rises when the host loads that field. It falls as soon as the run-in of that field's line has been sent, which tells the host that it may load the next pair.

Top module: `cc_line_inserter`

## Requirements
- R1: With `fmt_625` low, field 1 is inserted on line 21 and field 2 on line 284. With `fmt_625` high, field 1 is inserted on line 22 and field 2 on line 335. No other line value starts a window.
- R2: A window starts at the clock edge where `line_num` matches a caption line and `pix_cnt` equals START_PIX (default 250). `cc_valid` is high from the next cycle. It stays high for exactly the cycles n = 0, 1, ... for which floor(64·n / L) ≤ 51. L is the line length: 858 pixels when `fmt_625` is low, 864 when it is high.
- R3: The window consists of 52 half-bit cells in this order:
  - cells 0 to 13 are the run-in, with even cells high and odd cells low;
  - cells 14 to 17 are low and cells 18 and 19 are high (start bits 0, 0, 1);
  - cells 20 to 51 carry byte A and then byte B, LSB first, with two cells per bit.
- R4: In cycle n of the window, the cell index is floor(64·n / L), so the bit rate equals 32 times the line rate.
- R5: Inside the window, a one bit drives `cc_luma` = 160 (50 IRE above blanking) and a zero bit drives 64 (blanking level). Outside the window, `cc_luma` is 0 and `cc_valid` is 0.
- R6: If the field's enable is low when its window starts, the whole window is sent at the blanking code 64. `cc_valid` still covers the full window, and the field's pending flag is not cleared.
- R7: A load pulse sets that field's pending flag on the next edge. On an enabled line, the flag clears at the edge where the cell index reaches 14. A load in that same cycle keeps the flag set.
- R8: A load during a window does not change the bytes sent on that line. The new pair is sent on the field's next caption line.
- R9: After reset, `cc_valid` is 0, `cc_luma` is 0, both pending flags are 0 and all stored bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_625 | input | 1 | 0: 525-line numbering and length; 1: 625-line |
| line_num | input | 10 | Current scan line number |
| pix_cnt | input | 10 | Current pixel position within the line |
| en_f1 | input | 1 | Insert data on the field 1 line |
| en_f2 | input | 1 | Insert data on the field 2 line |
| ld_f1 | input | 1 | Load pulse for the field 1 byte pair |
| f1_byte_a | input | 8 | Field 1 first byte |
| f1_byte_b | input | 8 | Field 1 second byte |
| ld_f2 | input | 1 | Load pulse for the field 2 byte pair |
| f2_byte_a | input | 8 | Field 2 first byte |
| f2_byte_b | input | 8 | Field 2 second byte |
| cc_luma | output | 8 | Luma code to substitute |
| cc_valid | output | 1 | Substitution active |
| stat_f1 | output | 1 | Field 1 pair pending |
| stat_f2 | output | 1 | Field 2 pair pending |

## Verification
The assertions assume the following about the inputs:

- The pixel position does not return to the start position while a window is still running.
- Load pulses are single-cycle events.
- The format input does not change during a window.

Under these conditions, the cell index can only advance by one at a time, and the final cell always ends the window.

The bench keeps within these limits. It presents the start position for a single cycle and then parks `pix_cnt` at 0. It changes the format and the line only between windows. It raises a load for exactly one cycle, including one placed on the edge where the run-in ends.

// File: rtl/cc_pkg.sv
// Shared constants for the caption inserter: cell layout of one caption window.
package cc_pkg;
    localparam int RUNIN_HALVES = 14;                // seven run-in cycles, two cells each
    localparam int START_HALVES = 6;                 // start bits 0,0,1
    localparam int DATA_BITS    = 16;                // two bytes
    localparam int HALF_TOTAL   = RUNIN_HALVES + START_HALVES + 2 * DATA_BITS;
    localparam int HIDX_W       = $clog2(HALF_TOTAL);
    typedef logic [HIDX_W-1:0] hidx_t;
endpackage

// File: rtl/cc_bit_timer.sv
// Half-bit cell timer. After a start it steps a cell index through the window
// using a fractional accumulator: each pixel adds RATE_INC, and a cell ends
// when the sum reaches the line length. Assumes ppl > RATE_INC and that start
// is not raised again while busy.
module cc_bit_timer #(
    parameter int PIX_W    = 10,
    parameter int RATE_INC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PIX_W-1:0]  ppl,
    output logic              busy,
    output cc_pkg::hidx_t     hidx,
    output logic              runin_done
);
    import cc_pkg::*;
    localparam hidx_t LAST = hidx_t'(HALF_TOTAL - 1);

    logic [PIX_W:0] acc;
    logic [PIX_W:0] acc_nx;
    logic           tick;

    // next accumulator value and end-of-cell decision
    always_comb begin
        acc_nx = acc + (PIX_W+1)'(RATE_INC);
        tick   = acc_nx >= {1'b0, ppl};
    end

    // window sequencing: start, step cells, stop after the last cell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            hidx <= '0;
            acc  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            hidx <= '0;
            acc  <= '0;
        end else if (busy) begin
            if (tick) begin
                acc <= acc_nx - {1'b0, ppl};
                if (hidx == LAST) busy <= 1'b0;
                else              hidx <= hidx + 1'b1;
            end else begin
                acc <= acc_nx;
            end
        end
    end

    assign runin_done = busy && tick && (hidx == hidx_t'(RUNIN_HALVES - 1));

    // R4: the cell index never skips a cell
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || hidx == $past(hidx) || hidx == $past(hidx) + 1'b1));
    // R2: the window closes right after the final cell
    a_r2_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hidx == LAST && tick) |=> !busy);
endmodule

// File: rtl/cc_field_buf.sv
// Pending byte pair and pending flag for one field. A load captures both bytes
// and sets the flag; a clear drops the flag unless a load arrives in the same
// cycle. Assumes load is a single-cycle pulse.
module cc_field_buf (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld,
    input  logic [7:0] in_a,
    input  logic [7:0] in_b,
    input  logic       clr,
    output logic [7:0] buf_a,
    output logic [7:0] buf_b,
    output logic       pending
);
    // capture host bytes on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_a <= '0;
            buf_b <= '0;
        end else if (ld) begin
            buf_a <= in_a;
            buf_b <= in_b;
        end
    end

    // pending flag: load has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)   pending <= 1'b0;
        else if (ld)  pending <= 1'b1;
        else if (clr) pending <= 1'b0;
    end

    // R7: a load always leaves the flag set
    a_r7_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> pending);
    // R7: without load or clear the flag holds
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !clr) |=> $stable(pending));
endmodule

// File: rtl/cc_pattern.sv
// Maps a half-bit cell index to the line level: run-in, start bits, then
// byte A and byte B, LSB first, two cells per bit. Purely combinational.
module cc_pattern (
    input  cc_pkg::hidx_t hidx,
    input  logic [7:0]    byte_a,
    input  logic [7:0]    byte_b,
    output logic          bit_hi
);
    import cc_pkg::*;
    localparam int DATA0 = RUNIN_HALVES + START_HALVES;

    hidx_t      dofs;
    logic [3:0] k;

    // select the level for the current cell
    always_comb begin
        dofs = hidx - hidx_t'(DATA0);
        k    = dofs[4:1];
        if (hidx < hidx_t'(RUNIN_HALVES))
            bit_hi = ~hidx[0];
        else if (hidx < hidx_t'(DATA0))
            bit_hi = (hidx >= hidx_t'(DATA0 - 2));
        else if (!k[3])
            bit_hi = byte_a[k[2:0]];
        else
            bit_hi = byte_b[k[2:0]];
    end
endmodule

// File: rtl/cc_line_inserter.sv
// Caption line inserter top. Detects the caption line of either field, latches
// that field's pending pair and enable, and drives the two-level luma override
// across the window. Assumes line_num/pix_cnt come from the video timing and
// fmt_625 is steady during a window.
module cc_line_inserter #(
    parameter int PIX_W     = 10,
    parameter int LINE_W    = 10,
    parameter int START_PIX = 250,
    parameter int PPL_525   = 858,
    parameter int PPL_625   = 864,
    parameter int L525_F1   = 21,
    parameter int L525_F2   = 284,
    parameter int L625_F1   = 22,
    parameter int L625_F2   = 335,
    parameter int RATE_MULT = 32,
    parameter int LVL_BLANK = 64,
    parameter int LVL_ONE   = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_625,
    input  logic [LINE_W-1:0] line_num,
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic              en_f1,
    input  logic              en_f2,
    input  logic              ld_f1,
    input  logic [7:0]        f1_byte_a,
    input  logic [7:0]        f1_byte_b,
    input  logic              ld_f2,
    input  logic [7:0]        f2_byte_a,
    input  logic [7:0]        f2_byte_b,
    output logic [7:0]        cc_luma,
    output logic              cc_valid,
    output logic              stat_f1,
    output logic              stat_f2
);
    import cc_pkg::*;
    localparam int NF = 2;
    localparam logic [PIX_W-1:0] START_V = PIX_W'(START_PIX);
    localparam logic [7:0] BLANK_V = 8'(LVL_BLANK);
    localparam logic [7:0] ONE_V   = 8'(LVL_ONE);

    logic [PIX_W-1:0]  ppl;
    logic [LINE_W-1:0] tgt [NF];
    logic [NF-1:0]     hit, ld_v, en_v, clr_v, pend_v;
    logic [7:0]        in_a [NF], in_b [NF], buf_a [NF], buf_b [NF];
    logic              start, busy, runin_done, bit_hi;
    hidx_t             hidx;
    logic              cur_f, cur_en;
    logic [7:0]        act_a, act_b;

    // format-dependent line length and caption line numbers
    always_comb begin
        ppl    = fmt_625 ? PIX_W'(PPL_625) : PIX_W'(PPL_525);
        tgt[0] = fmt_625 ? LINE_W'(L625_F1) : LINE_W'(L525_F1);
        tgt[1] = fmt_625 ? LINE_W'(L625_F2) : LINE_W'(L525_F2);
    end

    assign ld_v  = {ld_f2, ld_f1};
    assign en_v  = {en_f2, en_f1};
    assign in_a[0] = f1_byte_a;
    assign in_b[0] = f1_byte_b;
    assign in_a[1] = f2_byte_a;
    assign in_b[1] = f2_byte_b;

    genvar f;
    generate
        for (f = 0; f < NF; f++) begin : g_field
            assign hit[f]   = (line_num == tgt[f]) && (pix_cnt == START_V);
            assign clr_v[f] = runin_done && cur_en && (cur_f == 1'(f));
            cc_field_buf u_buf (
                .clk(clk), .rst_n(rst_n), .ld(ld_v[f]),
                .in_a(in_a[f]), .in_b(in_b[f]), .clr(clr_v[f]),
                .buf_a(buf_a[f]), .buf_b(buf_b[f]), .pending(pend_v[f])
            );
        end
    endgenerate

    assign start = |hit;

    // capture working bytes, field and enable at window start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_f  <= 1'b0;
            cur_en <= 1'b0;
            act_a  <= '0;
            act_b  <= '0;
        end else if (start && !busy) begin
            cur_f  <= hit[1];
            cur_en <= hit[1] ? en_v[1] : en_v[0];
            act_a  <= hit[1] ? buf_a[1] : buf_a[0];
            act_b  <= hit[1] ? buf_b[1] : buf_b[0];
        end
    end

    cc_bit_timer #(.PIX_W(PIX_W), .RATE_INC(2 * RATE_MULT)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .ppl(ppl),
        .busy(busy), .hidx(hidx), .runin_done(runin_done)
    );

    cc_pattern u_pat (.hidx(hidx), .byte_a(act_a), .byte_b(act_b), .bit_hi(bit_hi));

    // output level selection
    always_comb begin
        cc_valid = busy;
        if (!busy)                 cc_luma = '0;
        else if (cur_en && bit_hi) cc_luma = ONE_V;
        else                       cc_luma = BLANK_V;
    end

    assign stat_f1 = pend_v[0];
    assign stat_f2 = pend_v[1];

    // R5: inside the window only the two legal levels appear
    a_r5_two_levels: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid |-> (cc_luma == BLANK_V || cc_luma == ONE_V));
    // R5: the override is zero outside the window
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_valid |-> (cc_luma == 8'd0));
    // R6: a disabled line stays at blanking
    a_r6_disabled_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_valid && !cur_en) |-> (cc_luma == BLANK_V));
    // R7: a disabled line never clears a pending flag
    a_r7_no_clear_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_valid && !cur_en && !ld_f1 && !ld_f2) |=> ($stable(stat_f1) && $stable(stat_f2)));
endmodule

// File: tb/cc_line_inserter_tb.sv
`timescale 1ns/1ps
module cc_line_inserter_tb;
    localparam int START_PIX = 250;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fmt_625 = 1'b0;
    logic [9:0] line_num = '0;
    logic [9:0] pix_cnt = '0;
    logic       en_f1 = 1'b1, en_f2 = 1'b1;
    logic       ld_f1 = 1'b0, ld_f2 = 1'b0;
    logic [7:0] f1_byte_a = '0, f1_byte_b = '0, f2_byte_a = '0, f2_byte_b = '0;
    logic [7:0] cc_luma;
    logic       cc_valid, stat_f1, stat_f2;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    cc_line_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_625(fmt_625), .line_num(line_num),
        .pix_cnt(pix_cnt), .en_f1(en_f1), .en_f2(en_f2),
        .ld_f1(ld_f1), .f1_byte_a(f1_byte_a), .f1_byte_b(f1_byte_b),
        .ld_f2(ld_f2), .f2_byte_a(f2_byte_a), .f2_byte_b(f2_byte_b),
        .cc_luma(cc_luma), .cc_valid(cc_valid), .stat_f1(stat_f1), .stat_f2(stat_f2)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int h, input logic [7:0] a, input logic [7:0] b);
        int k;
        if (h < 14) return (h % 2) == 0;
        if (h < 18) return 1'b0;
        if (h < 20) return 1'b1;
        k = (h - 20) / 2;
        return (k < 8) ? a[k] : b[k - 8];
    endfunction

    // Trigger one line and compare every cycle against the cell formula.
    // ld_at >= 0 pulses a field 2 load with na/nb in that window cycle.
    task automatic run_line(input logic fmt, input int line, input bit exp_act,
                            input bit exp_en, input logic [7:0] ea, input logic [7:0] eb,
                            input int ld_at, input logic [7:0] na, input logic [7:0] nb,
                            input string req);
        int ppl, mism, vcnt, ecnt, h, elvl, first_bad_act, first_bad_exp;
        ppl = fmt ? 864 : 858;
        mism = 0; vcnt = 0; ecnt = 0; first_bad_act = 0; first_bad_exp = 0;
        @(negedge clk);
        fmt_625 = fmt; line_num = 10'(line); pix_cnt = 10'(START_PIX);
        @(posedge clk);
        @(negedge clk);
        pix_cnt = '0;
        for (int n = 0; n < 900; n++) begin
            h = (64 * n) / ppl;
            if (exp_act && h <= 51) begin
                ecnt++;
                elvl = (exp_en && exp_bit(h, ea, eb)) ? 160 : 64;
            end else begin
                elvl = 0;
            end
            if (cc_valid) vcnt++;
            if (int'(cc_luma) != elvl || cc_valid != (elvl != 0)) begin
                if (mism == 0) begin first_bad_act = cc_luma; first_bad_exp = elvl; end
                mism++;
            end
            if (n == ld_at) begin ld_f2 = 1'b1; f2_byte_a = na; f2_byte_b = nb; end
            if (n == ld_at + 1) ld_f2 = 1'b0;
            @(posedge clk);
            @(negedge clk);
        end
        chk(mism == 0, {req, " waveform"}, first_bad_act, first_bad_exp);
        chk(vcnt == ecnt, {req, " window length"}, vcnt, ecnt);
    endtask

    task automatic load_f1(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk); ld_f1 = 1'b1; f1_byte_a = a; f1_byte_b = b;
        @(negedge clk); ld_f1 = 1'b0;
    endtask

    task automatic load_f2(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk); ld_f2 = 1'b1; f2_byte_a = a; f2_byte_b = b;
        @(negedge clk); ld_f2 = 1'b0;
    endtask

    task automatic t_reset;
        // R9: quiet outputs and clear flags after reset
        chk(cc_valid == 1'b0, "R9 valid", cc_valid, 0);
        chk(cc_luma == 8'd0, "R9 luma", cc_luma, 0);
        chk(stat_f1 == 1'b0 && stat_f2 == 1'b0, "R9 flags", {stat_f2, stat_f1}, 0);
        // R9: an enabled field 1 line with no load sends zero bytes
        run_line(1'b0, 21, 1'b1, 1'b1, 8'h00, 8'h00, -1, 8'h00, 8'h00, "R9 zero bytes");
    endtask

    task automatic t_load_status;
        load_f1(8'hA5, 8'h3C);
        // R7: the load sets only its own flag
        chk(stat_f1 == 1'b1 && stat_f2 == 1'b0, "R7 set on load", {stat_f2, stat_f1}, 1);
    endtask

    task automatic t_f1_525;
        // R1 R2 R3 R4 R5: field 1 line in 525-line mode
        run_line(1'b0, 21, 1'b1, 1'b1, 8'hA5, 8'h3C, -1, 8'h00, 8'h00, "R3 R4 f1 525");
        // R7: flag cleared after the run-in
        chk(stat_f1 == 1'b0, "R7 clear after run-in", stat_f1, 0);
    endtask

    task automatic t_wrong_lines;
        // R1: the 625-line field 1 number does nothing in 525-line mode
        run_line(1'b0, 22, 1'b0, 1'b1, 8'h00, 8'h00, -1, 8'h00, 8'h00, "R1 line 22 in 525");
        // R1: the 525-line number does nothing in 625-line mode
        run_line(1'b1, 21, 1'b0, 1'b1, 8'h00, 8'h00, -1, 8'h00, 8'h00, "R1 line 21 in 625");
    endtask

    task automatic t_f2_double_buffer;
        load_f2(8'h81, 8'h7E);
        // R8 R7: a load on the run-in end edge; the old bytes go out and the flag stays set
        run_line(1'b0, 284, 1'b1, 1'b1, 8'h81, 8'h7E, 187, 8'hC3, 8'h19, "R8 f2 line 284");
        chk(stat_f2 == 1'b1, "R7 load wins over clear", stat_f2, 1);
        // R8: the new pair appears on the next field 2 line
        run_line(1'b0, 284, 1'b1, 1'b1, 8'hC3, 8'h19, -1, 8'h00, 8'h00, "R8 next line");
        chk(stat_f2 == 1'b0, "R7 f2 cleared", stat_f2, 0);
    endtask

    task automatic t_625;
        load_f1(8'h0F, 8'hF0);
        load_f2(8'h55, 8'hAA);
        // R1 R4: 625-line numbers and the 864-pixel line length
        run_line(1'b1, 22, 1'b1, 1'b1, 8'h0F, 8'hF0, -1, 8'h00, 8'h00, "R1 R4 f1 625");
        run_line(1'b1, 335, 1'b1, 1'b1, 8'h55, 8'hAA, -1, 8'h00, 8'h00, "R1 R4 f2 625");
        chk(stat_f2 == 1'b0, "R7 f2 cleared line 335", stat_f2, 0);
    endtask

    task automatic t_disabled;
        load_f1(8'hFF, 8'hFF);
        @(negedge clk); en_f1 = 1'b0;
        // R6: blank window, full length
        run_line(1'b0, 21, 1'b1, 1'b0, 8'hFF, 8'hFF, -1, 8'h00, 8'h00, "R6 disabled f1");
        // R6: the flag is kept
        chk(stat_f1 == 1'b1, "R6 flag kept", stat_f1, 1);
        @(negedge clk); en_f1 = 1'b1;
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_status();
        t_f1_525();
        t_wrong_lines();
        t_f2_double_buffer();
        t_625();
        t_disabled();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule